// File: doc/BRIEF.md
# Data Memory Address Break Unit

This unit sits beside the data-memory access bus of a small microcontroller core and asks an emulation controller to halt the core when program execution touches a chosen data address. Each cycle it sees an access-valid flag, a read/write flag, the access address and an instruction-retire strobe. It compares the access address against a programmed address. A per-bit mask can widen that comparison to a set of addresses. An access-type select picks reads, writes, both or neither.

The unit does not break on the first hit. An occurrence count set at arming time decides which matching access is the final one. After that final access the request waits until the next instruction retires, then appears as a single-cycle pulse. The unit then disarms itself, and software must arm it again before it can fire a second time.

Top module: `dmab_unit`

## Requirements
- R1: An access address matches when it equals `cfg_addr_i` on every bit whose `cfg_mask_i` bit is 0. A mask bit of 1 makes that address bit don't-care.
- R2: Every address from all-zeros to all-ones can match, with no excluded range.
- R3: `cfg_kind_i` selects the accepted access type: 2'b01 reads only (`acc_write_i`=0), 2'b10 writes only (`acc_write_i`=1), 2'b11 either, 2'b00 none. A valid access of a type that is not accepted has no effect.
- R4: While armed, the break is taken only on the Nth matching access, where N is `cfg_count_i` sampled when `arm_i` is high. A count of 0 behaves as 1.
- R5: After the final matching access, the unit waits for the first `retire_i` in a cycle strictly after the access cycle. A retire in the same cycle as the access does not count. `break_o` is high for exactly one cycle, the cycle after that retire strobe.
- R6: Taking the final matching access disarms the unit. Later accesses cause no break until `arm_i` is asserted again.
- R7: `arm_i` reloads the count, arms the unit and cancels a pending break. An access in the same cycle as `arm_i` is not counted.
- R8: Synchronous active-high `rst` leaves the unit disarmed, with no pending break and `break_o` low.
- R9: Accesses while the unit is not armed have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_i | input | 1 | Arm and reload the occurrence count |
| cfg_addr_i | input | ADDR_W | Compare address |
| cfg_mask_i | input | ADDR_W | Per-bit don't-care mask (1 = ignore bit) |
| cfg_kind_i | input | 2 | Accepted access type |
| cfg_count_i | input | CNT_W | Occurrence count, sampled on arm |
| retire_i | input | 1 | Instruction-retire strobe |
| acc_valid_i | input | 1 | Data-memory access valid |
| acc_write_i | input | 1 | Access is a write (0 = read) |
| acc_addr_i | input | ADDR_W | Access address |
| break_o | output | 1 | One-cycle break request |

## Verification
The bench aims at the one-instruction delay. It retires an instruction in the same cycle as the final access, and a design that took that strobe as the delaying retire would pulse one instruction early. It also runs two-hit and zero-count arming: an off-by-one counter would fire on the first write, and a count of zero taken literally would wrap and never fire. Accesses after a break, accesses in the arming cycle, and re-arming over a pending break are also driven. A unit that failed to disarm would fire twice, and one that kept a stale pending flag would pulse after it was re-armed.

// File: rtl/dmab_pkg.sv
package dmab_pkg;

    localparam int DMAB_ADDR_W = 16;
    localparam int DMAB_CNT_W  = 8;

    typedef enum logic [1:0] {
        KIND_NONE  = 2'b00,
        KIND_READ  = 2'b01,
        KIND_WRITE = 2'b10,
        KIND_ANY   = 2'b11
    } acc_kind_e;

    typedef struct packed {
        logic armed;
        logic pending;
    } ctl_state_t;

    function automatic logic kind_accepts(input acc_kind_e kind, input logic is_write);
        case (kind)
            KIND_READ:  return !is_write;
            KIND_WRITE: return is_write;
            KIND_ANY:   return 1'b1;
            default:    return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/dmab_match.sv
module dmab_match
    import dmab_pkg::*;
#(
    parameter int ADDR_W = DMAB_ADDR_W
) (
    input  logic              acc_valid_i,
    input  logic              acc_write_i,
    input  logic [ADDR_W-1:0] acc_addr_i,
    input  logic [ADDR_W-1:0] cfg_addr_i,
    input  logic [ADDR_W-1:0] cfg_mask_i,
    input  logic [1:0]        cfg_kind_i,
    output logic              hit_o
);
    logic [ADDR_W-1:0] bit_ok;
    logic              type_ok;

    for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
        assign bit_ok[b] = cfg_mask_i[b] | (acc_addr_i[b] == cfg_addr_i[b]);
    end

    always_comb begin
        type_ok = kind_accepts(acc_kind_e'(cfg_kind_i), acc_write_i);
        hit_o   = acc_valid_i && type_ok && (&bit_ok);
    end
endmodule

// File: rtl/dmab_counter.sv
module dmab_counter
    import dmab_pkg::*;
#(
    parameter int CNT_W = DMAB_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm_i,
    input  logic [CNT_W-1:0] cfg_count_i,
    input  logic             hit_i,
    output logic             armed_o,
    output logic             final_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] remain_q;
    logic             armed_q;
    logic [CNT_W-1:0] load_val;

    always_comb begin
        load_val = (cfg_count_i == '0) ? ONE : cfg_count_i;
        final_o  = armed_q && hit_i && !arm_i && (remain_q == ONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q  <= 1'b0;
            remain_q <= '0;
        end else if (arm_i) begin
            armed_q  <= 1'b1;
            remain_q <= load_val;
        end else if (armed_q && hit_i) begin
            if (remain_q == ONE) armed_q <= 1'b0;
            else                 remain_q <= remain_q - ONE;
        end
    end

    assign armed_o = armed_q;

    assert_disarm_after_final_R6: assert property (@(posedge clk) disable iff (rst)
        final_o |=> !armed_q);
    assert_count_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
        armed_q |-> (remain_q != '0));
    assert_arm_sets_armed_R7: assert property (@(posedge clk) disable iff (rst)
        arm_i |=> armed_q);
endmodule

// File: rtl/dmab_fire.sv
module dmab_fire
    import dmab_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic arm_i,
    input  logic final_i,
    input  logic retire_i,
    output logic break_o
);
    ctl_state_t st_q;
    logic       brk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= '0;
            brk_q <= 1'b0;
        end else begin
            brk_q      <= st_q.pending && retire_i;
            st_q.armed <= 1'b0;
            if (arm_i)                          st_q.pending <= 1'b0;
            else if (final_i)                   st_q.pending <= 1'b1;
            else if (st_q.pending && retire_i)  st_q.pending <= 1'b0;
        end
    end

    assign break_o = brk_q;

    assert_pulse_single_R5: assert property (@(posedge clk) disable iff (rst)
        brk_q |=> !brk_q);
    assert_no_fire_same_cycle_R5: assert property (@(posedge clk) disable iff (rst)
        final_i |=> !brk_q);
endmodule

// File: rtl/dmab_unit.sv
module dmab_unit
    import dmab_pkg::*;
#(
    parameter int ADDR_W = DMAB_ADDR_W,
    parameter int CNT_W  = DMAB_CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arm_i,
    input  logic [ADDR_W-1:0] cfg_addr_i,
    input  logic [ADDR_W-1:0] cfg_mask_i,
    input  logic [1:0]        cfg_kind_i,
    input  logic [CNT_W-1:0]  cfg_count_i,
    input  logic              retire_i,
    input  logic              acc_valid_i,
    input  logic              acc_write_i,
    input  logic [ADDR_W-1:0] acc_addr_i,
    output logic              break_o
);
    logic hit;
    logic armed;
    logic final_hit;

    dmab_match #(.ADDR_W(ADDR_W)) u_match (
        .acc_valid_i (acc_valid_i),
        .acc_write_i (acc_write_i),
        .acc_addr_i  (acc_addr_i),
        .cfg_addr_i  (cfg_addr_i),
        .cfg_mask_i  (cfg_mask_i),
        .cfg_kind_i  (cfg_kind_i),
        .hit_o       (hit)
    );

    dmab_counter #(.CNT_W(CNT_W)) u_counter (
        .clk         (clk),
        .rst         (rst),
        .arm_i       (arm_i),
        .cfg_count_i (cfg_count_i),
        .hit_i       (hit),
        .armed_o     (armed),
        .final_o     (final_hit)
    );

    dmab_fire u_fire (
        .clk      (clk),
        .rst      (rst),
        .arm_i    (arm_i),
        .final_i  (final_hit),
        .retire_i (retire_i),
        .break_o  (break_o)
    );

    assert_break_after_retire_R5: assert property (@(posedge clk) disable iff (rst)
        break_o |-> $past(retire_i));
    assert_type_filter_R3: assert property (@(posedge clk) disable iff (rst)
        (acc_valid_i && cfg_kind_i == KIND_NONE) |-> !hit);
    assert_idle_when_disarmed_R9: assert property (@(posedge clk) disable iff (rst)
        (!armed && !arm_i) |=> !armed);
    assert_reset_quiet_R8: assert property (@(posedge clk)
        rst |=> !break_o);
endmodule

// File: tb/dmab_unit_tb_top.sv
module dmab_unit_tb_top;
    localparam int AW = 16;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          arm;
    logic [AW-1:0] caddr, cmask, aaddr;
    logic [1:0]    ckind;
    logic [CW-1:0] ccount;
    logic          retire, avalid, awrite;
    logic          brk;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    int pulses = 0;
    string phase = "R8";

    int m_armed = 0, m_rem = 0, m_pend = 0, m_brk = 0;

    always #10 clk = ~clk;

    dmab_unit #(.ADDR_W(AW), .CNT_W(CW)) dut_i (
        .clk(clk), .rst(rst), .arm_i(arm), .cfg_addr_i(caddr), .cfg_mask_i(cmask),
        .cfg_kind_i(ckind), .cfg_count_i(ccount), .retire_i(retire),
        .acc_valid_i(avalid), .acc_write_i(awrite), .acc_addr_i(aaddr), .break_o(brk)
    );

    function automatic bit ref_hit();
        bit tok;
        tok = (ckind == 2'b11) || (ckind == 2'b01 && !awrite) || (ckind == 2'b10 && awrite);
        return avalid && tok && (((aaddr ^ caddr) & ~cmask) == '0);
    endfunction

    always @(posedge clk) begin
        int nb, np;
        if (rst) begin
            m_armed = 0; m_rem = 0; m_pend = 0; m_brk = 0;
        end else begin
            nb = (m_pend != 0 && retire) ? 1 : 0;
            np = (nb != 0) ? 0 : m_pend;
            if (arm) begin
                m_armed = 1;
                m_rem = (ccount == 0) ? 1 : int'(ccount);
                np = 0;
            end else if (m_armed != 0 && ref_hit()) begin
                if (m_rem == 1) begin m_armed = 0; np = 1; end
                else m_rem = m_rem - 1;
            end
            m_brk = nb;
            m_pend = np;
        end
    end

    always @(negedge clk) begin
        cycles++;
        tests++;
        if (brk !== m_brk[0]) begin
            fails++;
            $display("FAIL %s cycle %0d: break_o actual %b expected %0d", phase, cycles, brk, m_brk);
        end
        if (brk === 1'b1) pulses++;
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic cyc(input bit a, input bit v, input bit w, input logic [AW-1:0] ad, input bit r);
        arm = a; avalid = v; awrite = w; aaddr = ad; retire = r;
        @(negedge clk);
    endtask

    task automatic idle(input int n, input bit r);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, '0, r);
    endtask

    task automatic expect_pulses(input int n, input string tag);
        tests++;
        if (pulses != n) begin
            fails++;
            $display("FAIL %s: pulse count actual %0d expected %0d", tag, pulses, n);
        end
        pulses = 0;
    endtask

    task automatic setup(input logic [AW-1:0] a, input logic [AW-1:0] m, input logic [1:0] k, input int c);
        caddr = a; cmask = m; ckind = k; ccount = CW'(c);
    endtask

    initial begin
        rst = 1'b1;
        setup(16'h0300, 16'h0000, 2'b10, 2);
        cyc(0, 0, 0, '0, 0);
        cyc(0, 0, 0, '0, 0);
        cyc(0, 1, 1, 16'h0300, 1);   // R8: access in reset ignored
        rst = 1'b0;
        idle(2, 1);
        expect_pulses(0, "R8");

        // R4/R5: two writes, retire in same cycle as access does not count
        phase = "R4";
        cyc(1, 0, 0, '0, 0);
        cyc(0, 1, 1, 16'h0300, 1);
        cyc(0, 0, 0, '0, 1);
        phase = "R5";
        cyc(0, 1, 1, 16'h0300, 1);
        idle(3, 0);
        cyc(0, 0, 0, '0, 1);
        idle(3, 1);
        expect_pulses(1, "R5");

        // R6: disarmed after firing
        phase = "R6";
        cyc(0, 1, 1, 16'h0300, 1);
        idle(3, 1);
        expect_pulses(0, "R6");

        // R9: accesses with unit never re-armed
        phase = "R9";
        setup(16'h0300, 16'h0000, 2'b11, 1);
        cyc(0, 1, 0, 16'h0300, 1);
        idle(3, 1);
        expect_pulses(0, "R9");

        // R1: mask low nibble
        phase = "R1";
        setup(16'h0120, 16'h000F, 2'b11, 1);
        cyc(1, 0, 0, '0, 0);
        cyc(0, 1, 0, 16'h0130, 0);
        idle(2, 1);
        expect_pulses(0, "R1");
        cyc(0, 1, 0, 16'h012A, 0);
        idle(3, 1);
        expect_pulses(1, "R1");

        // R2: extremes of address space
        phase = "R2";
        setup(16'hFFFF, 16'h0000, 2'b11, 1);
        cyc(1, 0, 0, '0, 0);
        cyc(0, 1, 1, 16'hFFFF, 0);
        idle(3, 1);
        expect_pulses(1, "R2");
        setup(16'h0000, 16'h0000, 2'b11, 1);
        cyc(1, 0, 0, '0, 0);
        cyc(0, 1, 0, 16'h0000, 1);
        idle(3, 1);
        expect_pulses(1, "R2");

        // R3: type filter
        phase = "R3";
        setup(16'h0040, 16'h0000, 2'b01, 1);
        cyc(1, 0, 0, '0, 0);
        cyc(0, 1, 1, 16'h0040, 1);
        idle(2, 1);
        expect_pulses(0, "R3");
        cyc(0, 1, 0, 16'h0040, 0);
        idle(3, 1);
        expect_pulses(1, "R3");
        setup(16'h0040, 16'h0000, 2'b00, 1);
        cyc(1, 0, 0, '0, 0);
        cyc(0, 1, 0, 16'h0040, 1);
        cyc(0, 1, 1, 16'h0040, 1);
        idle(2, 1);
        expect_pulses(0, "R3");

        // R4: count zero acts as one; count three
        phase = "R4";
        setup(16'h0055, 16'h0000, 2'b11, 0);
        cyc(1, 0, 0, '0, 0);
        cyc(0, 1, 0, 16'h0055, 0);
        idle(3, 1);
        expect_pulses(1, "R4");
        setup(16'h0055, 16'h0000, 2'b11, 3);
        cyc(1, 0, 0, '0, 0);
        cyc(0, 1, 0, 16'h0055, 1);
        cyc(0, 1, 1, 16'h0055, 1);
        idle(2, 1);
        expect_pulses(0, "R4");
        cyc(0, 1, 0, 16'h0055, 1);
        idle(3, 1);
        expect_pulses(1, "R4");

        // R7: access in arm cycle ignored; re-arm cancels pending
        phase = "R7";
        setup(16'h0077, 16'h0000, 2'b11, 1);
        cyc(1, 1, 0, 16'h0077, 0);
        idle(2, 1);
        expect_pulses(0, "R7");
        cyc(0, 1, 0, 16'h0077, 0);
        cyc(1, 0, 0, '0, 0);
        idle(3, 1);
        expect_pulses(0, "R7");
        cyc(0, 1, 1, 16'h0077, 0);
        idle(3, 1);
        expect_pulses(1, "R7");

        idle(2, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule